// File: doc/BRIEF.md
# Envelope Rate Generator with Phase Sequencing

This block produces the 8-bit loudness envelope of one synthesizer voice. A 15-bit rate counter advances on every clock. It is compared for exact equality against a limit. The limit comes from the 4-bit rate nybble of the current phase. On each match the counter returns to zero and the envelope takes one step: upward while attacking, downward while decaying or releasing. The downward steps pass through an exponential prescaler, so the envelope falls more slowly as it gets quieter.

The host writes a gate bit and four nybbles (attack rate, decay rate, sustain level and release rate) through a single write strobe. Raising the gate starts an attack. Attack hands over to decay at full scale, and decay settles at the sustain level. Lowering the gate starts the release, which ends at silence.

Two behaviours are part of the design. Because the compare is equality-only, lowering a limit below the running count makes the counter run on through its 15-bit wrap before the next step. On the cycle the gate rises, the decay nybble selects the limit for that single cycle.

Top module: `env_adsr_gen`

## Requirements
- R1: A synchronous active-high reset clears the envelope, the rate counter, all control fields and the gate to zero, and selects the release phase.
- R2: The step period in clocks for rate nybble 0..15 is 9, 32, 63, 95, 149, 220, 267, 313, 392, 977, 1954, 3126, 3907, 11720, 19532, 31251; the counter resets only when it equals the period minus one.
- R3: If the limit is lowered below the current count, no step occurs until the counter wraps past 0x7FFF and climbs back to the new limit.
- R4: On the one clock in which the latched gate is high and was low the clock before, the limit comes from the decay nybble and any match is an attack step; from the next clock on, the attack nybble selects the limit.
- R5: In attack each step adds one to the envelope; the step that reaches 0xFF also moves the phase to decay.
- R6: In decay, a step lowers the envelope only while it is above the sustain nybble times 0x11; at that level it holds while the gate stays high.
- R7: With the gate low the phase is release, and each step lowers the envelope by one at the release nybble's rate.
- R8: In decay and release only every Nth rate match is a step: N is 1 above 0x5D, 2 above 0x36, 4 above 0x1A, 8 above 0x0E, 16 above 0x06, and 30 otherwise (compared with the envelope value before the step).
- R9: In release the envelope never goes below 0x00 and stays at 0x00 once reached.
- R10: Gate and nybble inputs take effect only on a clock with the write strobe high; without the strobe, changes on them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe latching gate and nybbles |
| gate_in | input | 1 | Gate value to latch |
| atk_in | input | 4 | Attack rate nybble |
| dec_in | input | 4 | Decay rate nybble |
| sus_in | input | 4 | Sustain level nybble |
| rel_in | input | 4 | Release rate nybble |
| env_level | output | 8 | Envelope value, readable every cycle |

## Verification
A wrong rate counter value shows up at the envelope output as a step interval that is off by some clocks. This is visible within one period, from 9 clocks up to 31251 clocks. A wrong phase appears at the next step as a move in the wrong direction. A wrong prescaler count only appears at the quiet end of a release, as intervals that are not 9·N. A mistimed glitch cycle appears as an attack step arriving one counter phase early or late. The bench therefore checks measured intervals, the direction of each step and the final hold levels, and it also follows a cycle-level behavioural model on every clock.

// File: rtl/env_adsr_pkg.sv
package env_adsr_pkg;

    localparam int NYB_W = 4;
    localparam int ENV_W = 2 * NYB_W;
    localparam int CNT_W = 15;
    localparam int PRE_W = 5;

    typedef enum logic [1:0] {
        PH_ATTACK  = 2'd0,
        PH_DECAY   = 2'd1,
        PH_RELEASE = 2'd2
    } phase_e;

    typedef struct packed {
        logic             gate;
        logic [NYB_W-1:0] atk;
        logic [NYB_W-1:0] dec;
        logic [NYB_W-1:0] sus;
        logic [NYB_W-1:0] rel;
    } ctrl_t;

    // counter value at which a step fires (period minus one)
    function automatic logic [CNT_W-1:0] rate_limit(input logic [NYB_W-1:0] r);
        logic [CNT_W-1:0] v;
        case (r)
            4'd0:  v = 15'd8;
            4'd1:  v = 15'd31;
            4'd2:  v = 15'd62;
            4'd3:  v = 15'd94;
            4'd4:  v = 15'd148;
            4'd5:  v = 15'd219;
            4'd6:  v = 15'd266;
            4'd7:  v = 15'd312;
            4'd8:  v = 15'd391;
            4'd9:  v = 15'd976;
            4'd10: v = 15'd1953;
            4'd11: v = 15'd3125;
            4'd12: v = 15'd3906;
            4'd13: v = 15'd11719;
            4'd14: v = 15'd19531;
            default: v = 15'd31250;
        endcase
        return v;
    endfunction

    // downward step divisor as a function of the present level
    function automatic logic [PRE_W-1:0] exp_div(input logic [ENV_W-1:0] lvl);
        logic [PRE_W-1:0] d;
        if (lvl > 8'h5D)      d = 5'd1;
        else if (lvl > 8'h36) d = 5'd2;
        else if (lvl > 8'h1A) d = 5'd4;
        else if (lvl > 8'h0E) d = 5'd8;
        else if (lvl > 8'h06) d = 5'd16;
        else                  d = 5'd30;
        return d;
    endfunction

endpackage

// File: rtl/env_ctrl_regs.sv
module env_ctrl_regs
    import env_adsr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  ctrl_t wr_data,
    output ctrl_t ctrl_q,
    output logic  gate_rise
);
    logic gate_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            gate_d <= 1'b0;
        end else begin
            gate_d <= ctrl_q.gate;
            if (wr_en) ctrl_q <= wr_data;
        end
    end

    assign gate_rise = ctrl_q.gate & ~gate_d;

    // R10: fields move only on a strobe
    p_hold_without_write_r10: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(ctrl_q));

endmodule

// File: rtl/env_rate_counter.sv
module env_rate_counter #(
    parameter int CW = 15
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] limit,
    output logic          match
);
    logic [CW-1:0] cnt;

    assign match = (cnt == limit);

    always_ff @(posedge clk) begin
        if (rst)        cnt <= '0;
        else if (match) cnt <= '0;
        else            cnt <= cnt + 1'b1;
    end

    // R2: free-running increment between matches
    p_count_up_r2: assert property (@(posedge clk) disable iff (rst)
        (!match && cnt != '1) |=> cnt == $past(cnt) + 1'b1);

    // R3: with no match at the top, the count wraps to zero
    p_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        (!match && cnt == '1) |=> cnt == '0);

    p_match_clears_r2: assert property (@(posedge clk) disable iff (rst)
        match |=> cnt == '0);

endmodule

// File: rtl/env_exp_prescaler.sv
module env_exp_prescaler
    import env_adsr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             tick,
    input  logic [ENV_W-1:0] level,
    output logic             fire
);
    logic [PRE_W-1:0] pcnt;
    logic [PRE_W-1:0] top;

    assign top  = exp_div(level) - 5'd1;
    assign fire = tick && (pcnt >= top);

    always_ff @(posedge clk) begin
        if (rst || clear)  pcnt <= '0;
        else if (fire)     pcnt <= '0;
        else if (tick)     pcnt <= pcnt + 1'b1;
    end

    // R8: the divisor count never passes the largest divisor
    p_pre_bound_r8: assert property (@(posedge clk) disable iff (rst)
        pcnt < 5'd30);

endmodule

// File: rtl/env_level_fsm.sv
module env_level_fsm
    import env_adsr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             gate,
    input  logic             gate_rise,
    input  logic [NYB_W-1:0] sus,
    input  logic             rate_hit,
    input  logic             pre_fire,
    output phase_e           phase_eff,
    output logic [ENV_W-1:0] env_q
);
    localparam logic [ENV_W-1:0] ENV_MAX = '1;

    phase_e           phase_q, phase_n;
    logic [ENV_W-1:0] env_n;
    logic [ENV_W-1:0] target;

    assign target    = {sus, sus};
    assign phase_eff = gate_rise ? PH_ATTACK : phase_q;

    always_comb begin
        env_n   = env_q;
        phase_n = phase_eff;
        case (phase_eff)
            PH_ATTACK: begin
                if (rate_hit) begin
                    if (env_q == ENV_MAX) begin
                        phase_n = PH_DECAY;
                    end else begin
                        env_n = env_q + 1'b1;
                        if (env_n == ENV_MAX) phase_n = PH_DECAY;
                    end
                end
            end
            PH_DECAY: begin
                if (pre_fire && env_q > target) env_n = env_q - 1'b1;
            end
            default: begin
                if (pre_fire && env_q != '0) env_n = env_q - 1'b1;
            end
        endcase
        if (!gate) phase_n = PH_RELEASE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_RELEASE;
            env_q   <= '0;
        end else begin
            phase_q <= phase_n;
            env_q   <= env_n;
        end
    end

    // R5: an attack match raises the level by one
    p_attack_step_r5: assert property (@(posedge clk) disable iff (rst)
        (phase_eff == PH_ATTACK && rate_hit && env_q != ENV_MAX)
        |=> env_q == ENV_W'($past(env_q) + 1'b1));

    // R6: no motion once the sustain level is reached
    p_sustain_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (phase_eff == PH_DECAY && env_q == target) |=> $stable(env_q));

    // R9: release floor
    p_floor_r9: assert property (@(posedge clk) disable iff (rst)
        (phase_eff == PH_RELEASE && env_q == '0) |=> env_q == '0);

    // R7: gate low always leads to release
    p_release_entry_r7: assert property (@(posedge clk) disable iff (rst)
        !gate |=> phase_q == PH_RELEASE);

    // R4: a rise without a match leaves the block attacking
    p_rise_attack_r4: assert property (@(posedge clk) disable iff (rst)
        (gate_rise && !rate_hit) |=> phase_q == PH_ATTACK);

endmodule

// File: rtl/env_adsr_gen.sv
module env_adsr_gen
    import env_adsr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic       gate_in,
    input  logic [3:0] atk_in,
    input  logic [3:0] dec_in,
    input  logic [3:0] sus_in,
    input  logic [3:0] rel_in,
    output logic [7:0] env_level
);
    ctrl_t            wr_data, ctrl_q;
    logic             gate_rise;
    logic [NYB_W-1:0] sel_nyb;
    logic [CNT_W-1:0] limit;
    logic             rate_hit;
    logic             pre_fire;
    phase_e           phase_eff;
    logic [ENV_W-1:0] env_q;

    assign wr_data = '{gate: gate_in, atk: atk_in, dec: dec_in, sus: sus_in, rel: rel_in};

    env_ctrl_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .ctrl_q    (ctrl_q),
        .gate_rise (gate_rise)
    );

    // the rising-gate cycle borrows the decay nybble
    always_comb begin
        if (gate_rise) sel_nyb = ctrl_q.dec;
        else begin
            case (phase_eff)
                PH_ATTACK: sel_nyb = ctrl_q.atk;
                PH_DECAY:  sel_nyb = ctrl_q.dec;
                default:   sel_nyb = ctrl_q.rel;
            endcase
        end
    end

    assign limit = rate_limit(sel_nyb);

    env_rate_counter #(.CW(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .limit (limit),
        .match (rate_hit)
    );

    env_exp_prescaler u_pre (
        .clk   (clk),
        .rst   (rst),
        .clear (phase_eff == PH_ATTACK),
        .tick  (rate_hit && phase_eff != PH_ATTACK),
        .level (env_q),
        .fire  (pre_fire)
    );

    env_level_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .gate      (ctrl_q.gate),
        .gate_rise (gate_rise),
        .sus       (ctrl_q.sus),
        .rate_hit  (rate_hit),
        .pre_fire  (pre_fire),
        .phase_eff (phase_eff),
        .env_q     (env_q)
    );

    assign env_level = env_q;

    // R1: reset leaves silence on the output
    p_reset_zero_r1: assert property (@(posedge clk)
        rst |=> env_level == 8'h00);

endmodule

// File: tb/env_adsr_gen_test.sv
module env_adsr_gen_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic       gate_in = 1'b0;
    logic [3:0] atk_in = '0, dec_in = '0, sus_in = '0, rel_in = '0;
    logic [7:0] env_level;

    int checks = 0, errors = 0, cyc = 0;
    bit done = 0;
    string tag = "R1";

    env_adsr_gen uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .gate_in(gate_in),
        .atk_in(atk_in), .dec_in(dec_in), .sus_in(sus_in), .rel_in(rel_in),
        .env_level(env_level)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int period_of(input int r);
        int t[16] = '{9, 32, 63, 95, 149, 220, 267, 313, 392, 977,
                      1954, 3126, 3907, 11720, 19532, 31251};
        return t[r];
    endfunction

    function automatic int div_of(input int l);
        if (l > 'h5D) return 1;
        if (l > 'h36) return 2;
        if (l > 'h1A) return 4;
        if (l > 'h0E) return 8;
        if (l > 'h06) return 16;
        return 30;
    endfunction

    task automatic check(input string req, input bit ok, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // behavioural reference, phases 0 attack 1 decay 2 release
    int m_cnt, m_env, m_ph, m_ex;
    int m_g, m_gd, m_a, m_d, m_s, m_r;
    int mismatch_prints = 0;

    always @(posedge clk) begin
        int eph, nyb, hit, nenv, nph, nex;
        cyc++;
        if (rst) begin
            m_cnt = 0; m_env = 0; m_ph = 2; m_ex = 0;
            m_g = 0; m_gd = 0; m_a = 0; m_d = 0; m_s = 0; m_r = 0;
        end else begin
            eph = (m_g && !m_gd) ? 0 : m_ph;
            nyb = (m_g && !m_gd) ? m_d : (eph == 0 ? m_a : (eph == 1 ? m_d : m_r));
            hit = (m_cnt == period_of(nyb) - 1);
            nenv = m_env; nph = eph; nex = m_ex;
            if (eph == 0) begin
                nex = 0;
                if (hit) begin
                    if (m_env == 255) nph = 1;
                    else begin
                        nenv = m_env + 1;
                        if (nenv == 255) nph = 1;
                    end
                end
            end else if (hit) begin
                if (m_ex >= div_of(m_env) - 1) begin
                    nex = 0;
                    if (eph == 1) begin
                        if (m_env > m_s * 17) nenv = m_env - 1;
                    end else if (m_env != 0) nenv = m_env - 1;
                end else nex = m_ex + 1;
            end
            if (!m_g) nph = 2;
            m_cnt = hit ? 0 : ((m_cnt + 1) & 32'h7FFF);
            m_env = nenv; m_ph = nph; m_ex = nex;
            m_gd = m_g;
            if (wr_en) begin
                m_g = gate_in; m_a = atk_in; m_d = dec_in; m_s = sus_in; m_r = rel_in;
            end
        end
    end

    always @(negedge clk) begin
        if (cyc >= 1 && !done) begin
            checks++;
            if (env_level !== 8'(m_env)) begin
                errors++;
                if (mismatch_prints < 10) begin
                    mismatch_prints++;
                    $display("FAIL %s model actual=%0d expected=%0d", tag, env_level, m_env);
                end
            end
        end
    end

    always @(posedge clk) begin
        if (cyc > 190000 && !done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
    endtask

    task automatic write(input bit g, input int a, input int d, input int s, input int r);
        @(negedge clk);
        gate_in = g; atk_in = 4'(a); dec_in = 4'(d); sus_in = 4'(s); rel_in = 4'(r);
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic next_change(output int n);
        logic [7:0] p;
        p = env_level; n = 0;
        do begin @(negedge clk); n++; end while (env_level == p && n < 70000);
    endtask

    initial begin
        int n, hits, lvl;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        tag = "R1";
        check("R1 reset level", env_level == 0, env_level, 0);
        do_reset();
        check("R1 level after reset", env_level == 0, env_level, 0);

        // step periods from the rate table
        tag = "R2";
        for (int r = 0; r < 16; r++) begin
            if (r > 8 && r != 15) continue;
            do_reset();
            write(1, r, r, 0, r);
            next_change(n);
            next_change(n);
            check("R2 attack period", n == period_of(r), n, period_of(r));
        end

        // glitch cycle: one counter phase of nine gives an instant step
        tag = "R4";
        hits = 0;
        for (int off = 0; off < 9; off++) begin
            do_reset();
            repeat (off) @(negedge clk);
            write(1, 15, 0, 0, 0);
            repeat (10) @(negedge clk);
            if (env_level == 1) hits++;
        end
        check("R4 decay-limit step on rise", hits == 1, hits, 1);

        // full attack, decay to sustain
        tag = "R5";
        do_reset();
        write(1, 0, 0, 8, 0);
        n = 0;
        while (env_level != 8'hFF && n < 5000) begin @(negedge clk); n++; end
        check("R5 attack reaches full scale", env_level == 8'hFF, env_level, 255);
        next_change(n);
        check("R5 decay follows full scale", env_level == 8'hFE, env_level, 254);
        check("R5 decay step one period later", n == 9, n, 9);
        tag = "R6";
        n = 0;
        while (env_level != 8'h88 && n < 5000) begin @(negedge clk); n++; end
        repeat (500) @(negedge clk);
        check("R6 sustain hold", env_level == 8'h88, env_level, 136);

        // inputs without strobe are ignored
        tag = "R10";
        @(negedge clk);
        gate_in = 0; atk_in = 4'd3; dec_in = 4'd0; sus_in = 4'd0; rel_in = 4'd0;
        repeat (300) @(negedge clk);
        check("R10 no strobe no effect", env_level == 8'h88, env_level, 136);

        // release with prescaled intervals
        tag = "R7";
        write(0, 0, 0, 8, 0);
        lvl = env_level;
        next_change(n);
        check("R7 release steps down", env_level == 8'(lvl - 1), env_level, lvl - 1);
        tag = "R8";
        lvl = env_level;
        while (env_level != 0 && n < 70000) begin
            next_change(n);
            if (env_level != 8'(lvl - 1))
                check("R7 single step down", 0, env_level, lvl - 1);
            if (lvl == 'h50 || lvl == 'h30 || lvl == 'h10 || lvl == 'h08 || lvl == 'h03)
                check("R8 prescaled interval", n == 9 * div_of(lvl), n, 9 * div_of(lvl));
            lvl = env_level;
        end
        tag = "R9";
        repeat (1000) @(negedge clk);
        check("R9 floor holds", env_level == 0, env_level, 0);

        // lowering the limit below the count waits for the wrap
        tag = "R3";
        do_reset();
        write(1, 15, 15, 0, 15);
        repeat (2000) @(negedge clk);
        write(1, 0, 15, 0, 15);
        next_change(n);
        check("R3 wrap delay", n > 30600 && n < 30950, n, 30777);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule